// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

This block sits on the master side of a two-wire serial bus. It finds out when a serial memory has finished its self-timed internal write. Upstream logic sends the write command through a byte-level bus engine and then raises a request. The sequencer issues the stop condition that closes the write, which is what starts the memory's internal cycle. It then probes the device at once and keeps probing. Each probe is a start condition followed by the control byte with the direction bit cleared.

A probe that is not acknowledged means the device is still busy writing, and this is not treated as an error. The sequencer closes that probe with a stop and sends another one. When a probe is acknowledged, the sequencer pulses `done_o` and leaves the bus open, so the next read or write can follow straight away. A programmable limit on the number of unanswered probes stops the loop, and a sticky timeout flag is raised.

The bus engine is modelled as a command/response handshake. A command is presented with `cmd_valid_o` and held until the engine pulses `cmd_done_i`. For a byte command, the engine returns the acknowledge on `cmd_ack_i` in the same cycle.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o` and `cmd_valid_o` are all low.
- R2: A `poll_req_i` pulse seen while idle sets `busy_o` in the next cycle. In that same cycle the first command is presented: a STOP (`cmd_o` = 2), which ends the pending write.
- R3: Each probe is a START command (`cmd_o` = 0) followed by a WRITE command (`cmd_o` = 1). The byte of the WRITE is `{dev_addr_i, 1'b0}`: the device address sits in bits 7:1 and the direction bit 0 is zero.
- R4: A command stays presented, with `cmd_o` and `cmd_byte_o` unchanged, until the cycle in which `cmd_done_i` is high.
- R5: If the WRITE of a probe completes with `cmd_ack_i` = 0 (no acknowledge) and the limit is not yet reached, a STOP is issued and then a new probe starts.
- R6: If the WRITE of a probe completes with `cmd_ack_i` = 1, no STOP is issued. `done_o` is high for exactly one cycle, and the block then returns to idle.
- R7: When the number of unacknowledged probes reaches `max_polls_i`, a final STOP is issued, `timeout_o` is set, `busy_o` falls and no `done_o` pulse occurs. A `max_polls_i` of 0 acts as 1.
- R8: `timeout_o` stays high while the block is idle, and it is cleared in the cycle after a new request is accepted.
- R9: A `poll_req_i` pulse while `busy_o` is high is ignored: the command sequence and the outcome of the running poll are unchanged.
- R10: `busy_o` stays high from acceptance until the cycle in which `done_o` pulses, or until the final STOP after a timeout completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_req_i | input | 1 | Request to end the current write and poll for completion |
| dev_addr_i | input | 7 | Device address placed in control byte bits 7:1 |
| max_polls_i | input | 16 | Maximum number of unacknowledged probes (0 acts as 1) |
| cmd_valid_o | output | 1 | Command presented to the bus engine |
| cmd_o | output | 2 | Command code: 0 START, 1 WRITE, 2 STOP |
| cmd_byte_o | output | 8 | Byte sent by a WRITE command |
| cmd_done_i | input | 1 | Engine finished the presented command |
| cmd_ack_i | input | 1 | Acknowledge received for a WRITE (1 = acknowledged) |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle pulse: device acknowledged the probe |
| timeout_o | output | 1 | Sticky: probe limit reached without an acknowledge |

## Verification
The hardest case is the boundary where the acknowledge arrives on the very last permitted probe, compared with the case where that probe is refused. Seen from the ports, these two differ only in whether a STOP follows the last probe and in which flag is raised. The bench models the bus engine and controls, per job, how many probes are refused before the device answers. It runs one job with one refusal fewer than the limit, one with exactly the limit, and one with a limit of zero. It also changes the engine latency so that commands are held over several cycles. A scoreboard compares every completed command with the sequence predicted from the refusal count and the limit.

// File: rtl/ack_poll_pkg.sv
package ack_poll_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_STOP  = 2'd2
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_STOP,
    ST_START,
    ST_SEND_CTRL,
    ST_CHECK_ACK,
    ST_STOP_RETRY,
    ST_DONE
  } poll_state_e;
endpackage

// File: rtl/ack_poll_counter.sv
module ack_poll_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_eff;

  assign lim_eff = (limit_i == '0) ? ONE : limit_i;
  // current probe is the last one allowed
  assign last_o  = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, lim_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + ONE;
  end

  // R7: the refusal count never passes the limit
  a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> ({1'b0, cnt_q} + (CNT_W+1)'(1)) < {1'b0, lim_eff});
endmodule

// File: rtl/ack_poll_fsm.sv
module ack_poll_fsm
  import ack_poll_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cmd_done_i,
  input  logic              cmd_ack_i,
  input  logic              last_i,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  poll_state_e state_q, state_d;
  logic        ack_q;
  logic        timeout_q;
  bus_cmd_e    cmd;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_i)      state_d = ST_WR_STOP;
      ST_WR_STOP:    if (cmd_done_i) state_d = ST_START;
      ST_START:      if (cmd_done_i) state_d = ST_SEND_CTRL;
      ST_SEND_CTRL:  if (cmd_done_i) state_d = ST_CHECK_ACK;
      ST_CHECK_ACK:                  state_d = ack_q ? ST_DONE : ST_STOP_RETRY;
      ST_STOP_RETRY: if (cmd_done_i) state_d = timeout_q ? ST_IDLE : ST_START;
      ST_DONE:                       state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ack_q     <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SEND_CTRL && cmd_done_i) ack_q <= cmd_ack_i;
      if (cnt_clr_o) timeout_q <= 1'b0;
      else if (state_q == ST_CHECK_ACK && !ack_q && last_i) timeout_q <= 1'b1;
    end
  end

  always_comb begin
    cmd         = CMD_START;
    cmd_valid_o = 1'b1;
    unique case (state_q)
      ST_WR_STOP, ST_STOP_RETRY: cmd = CMD_STOP;
      ST_START:                  cmd = CMD_START;
      ST_SEND_CTRL:              cmd = CMD_WRITE;
      default:                   cmd_valid_o = 1'b0;
    endcase
  end

  assign cmd_o      = cmd;
  assign cmd_byte_o = (state_q == ST_SEND_CTRL) ? {addr_i, 1'b0} : '0;
  assign cnt_clr_o  = (state_q == ST_IDLE) && req_i;
  assign cnt_inc_o  = (state_q == ST_CHECK_ACK) && !ack_q && !last_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign timeout_o  = timeout_q;

  // R4: command held until the engine completes it
  a_r4_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_o) && $stable(cmd_byte_o));
  // R6: single-cycle done, then idle
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R2: a poll opens with the stop that ends the write
  a_r2_first_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> cmd_valid_o && cmd_o == CMD_STOP);
  // R7: a timed-out poll never reports done
  a_r7_no_done_on_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !timeout_o);
  // R8: timeout is sticky while idle
  a_r8_timeout_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !busy_o && !req_i |=> timeout_o);
  // R9: requests while busy do not restart the sequence
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && !(cmd_valid_o && cmd_o == CMD_STOP && cmd_done_i) |=> busy_o);
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 16,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_req_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  input  logic              cmd_done_i,
  input  logic              cmd_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  logic cnt_clr, cnt_inc, last;

  ack_poll_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .limit_i (max_polls_i),
    .last_o  (last)
  );

  ack_poll_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (poll_req_i),
    .addr_i      (dev_addr_i),
    .cmd_done_i  (cmd_done_i),
    .cmd_ack_i   (cmd_ack_i),
    .last_i      (last),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .cmd_byte_o  (cmd_byte_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
  );

  // R1: no command without an active poll
  a_r1_cmd_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);
endmodule

// File: tb/sim_ack_poll_seq.sv
module sim_ack_poll_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] limit = '0;
  logic        cmd_valid;
  logic [1:0]  cmd;
  logic [7:0]  cmd_byte;
  logic        cmd_done = 1'b0;
  logic        cmd_ack = 1'b0;
  logic        busy, done, timeout;

  int n_chk = 0, n_bad = 0;
  logic [9:0] exp_q[$];
  int nack_left = 0;
  int latency = 0;
  int done_cnt = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  ack_poll_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .poll_req_i(req), .dev_addr_i(addr),
    .max_polls_i(limit), .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_byte_o(cmd_byte),
    .cmd_done_i(cmd_done), .cmd_ack_i(cmd_ack), .busy_o(busy), .done_o(done),
    .timeout_o(timeout)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, expv, $time);
    end
  endtask

  // bus engine model and scoreboard monitor
  initial begin
    bit active = 0;
    int cyc = 0;
    logic [1:0] h_cmd;
    logic [7:0] h_byte;
    bit held = 1;
    forever begin
      @(negedge clk);
      if (cmd_done) begin
        cmd_done = 1'b0;
        cmd_ack  = 1'b0;
      end else if (cmd_valid) begin
        if (!active) begin
          active = 1; cyc = 0; h_cmd = cmd; h_byte = cmd_byte; held = 1;
        end else if (cmd != h_cmd || cmd_byte != h_byte) held = 0;
        cyc++;
        if (cyc > latency) begin
          logic [9:0] e;
          active = 0;
          chk(held, "R4 held", 0, 1);
          if (exp_q.size() == 0) begin
            chk(0, "R5 extra command", int'(cmd), -1);
          end else begin
            e = exp_q.pop_front();
            chk({cmd, cmd_byte} == e, "R3/R5 command", int'({cmd, cmd_byte}), int'(e));
          end
          if (cmd == 2'd1) begin
            cmd_ack = (nack_left == 0);
            if (nack_left > 0) nack_left--;
          end
          cmd_done = 1'b1;
        end
      end
    end
  end

  // done pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        if (!busy) chk(0, "R10 busy at done", 0, 1);
      end
    end
  end

  // driver: predicts the command sequence and pushes it into the scoreboard
  task automatic build_job(input logic [6:0] a, input int nacks, input int lim,
                           output bit exp_to);
    int le = (lim == 0) ? 1 : lim;
    int probes = (nacks + 1 < le) ? nacks + 1 : le;
    exp_q.push_back({2'd2, 8'h00});
    for (int p = 0; p < probes; p++) begin
      exp_q.push_back({2'd0, 8'h00});
      exp_q.push_back({2'd1, a, 1'b0});
      if (p < nacks) exp_q.push_back({2'd2, 8'h00});
    end
    exp_to = (nacks >= le);
  endtask

  task automatic run_job(input logic [6:0] a, input int nacks, input int lim,
                         input int lat, input bit poke);
    bit exp_to;
    int n = 0;
    addr = a; limit = 16'(lim); latency = lat; nack_left = nacks;
    build_job(a, nacks, lim, exp_to);
    done_cnt = 0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    chk(cmd_valid && cmd == 2'd2, "R2 first STOP", int'(cmd), 2);
    chk(timeout == 1'b0, "R8 timeout cleared", int'(timeout), 0);
    while (busy) begin
      @(negedge clk);
      n++;
      if (poke && n == 7) req = 1'b1;   // R9 request while busy
      if (poke && n == 8) req = 1'b0;
    end
    chk(exp_q.size() == 0, "R3/R5 all commands issued", exp_q.size(), 0);
    chk(done_cnt == (exp_to ? 0 : 1), exp_to ? "R7 no done" : "R6 one done pulse",
        done_cnt, exp_to ? 0 : 1);
    chk(timeout == exp_to, "R7 timeout flag", int'(timeout), int'(exp_to));
    chk(!cmd_valid, "R10 idle after finish", int'(cmd_valid), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(!busy, "R9 no restart", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(!done, "R1 done", int'(done), 0);
    chk(!timeout, "R1 timeout", int'(timeout), 0);
    chk(!cmd_valid, "R1 cmd_valid", int'(cmd_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_job(7'h50, 0, 4, 0, 0);   // R6 immediate ack
    run_job(7'h50, 3, 4, 2, 0);   // R5 ack on last allowed probe
    run_job(7'h2a, 4, 4, 1, 0);   // R7 limit reached
    repeat (20) @(negedge clk);
    chk(timeout == 1'b1, "R8 timeout sticky", int'(timeout), 1);
    run_job(7'h13, 1, 4, 3, 0);   // R8 cleared on accept
    run_job(7'h7f, 5, 0, 0, 0);   // R7 limit zero acts as one
    run_job(7'h01, 2, 6, 1, 1);   // R9 request while busy
    run_job(7'h3c, 6, 9, 0, 0);   // R5 several retries

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule